// File: doc/BRIEF.md
# Sprite Pursuit Motion Controller

This block moves a small set of sprites so that the chasing sprites home in on one chosen quarry sprite. Software loads each sprite's X/Y position through a register port. It picks which sprite is the quarry, sets an enable mask of chasers, and programs the colour that counts as open floor. On every frame tick the block works through the chasers one at a time. It moves each chaser by at most one pixel toward the quarry, and a move is allowed only when the background pixel at the new spot is the open-floor colour. Walls and screen borders are drawn in other colours, so the chasers slide along or stop at them instead of passing through.

The background is reached through a lookup port. The block drives a coordinate with a read strobe, and the display memory returns that pixel's colour on the following cycle. Whenever a chaser's 8x8 box overlaps the quarry's box, the block latches a per-sprite hit flag. The flag stays set until software writes a one to its bit. Drawing the sprites is left to other logic.

Top module: `sprite_chase_ctrl`

## Requirements
- R1: After reset, every register reads zero and `hit_flags` is zero. This covers all positions, the quarry select, the enable mask, the floor colour and the hit flags.
- R2: Register addresses: 0 = quarry select (low IDX_W bits), 1 = chaser enable mask (bit i for sprite i), 2 = floor colour (8 bits), 3 = hit flags. For sprite i, address 4+2i holds X and address 5+2i holds Y, each 10 bits. Reads are combinational, unused upper bits read zero, and written bits above a field's width are dropped.
- R3: One frame tick moves each chaser by at most one pixel, along one axis only, and always toward the quarry.
- R4: A chaser first tries the axis whose distance to the quarry is larger. When the two distances are equal it tries X first. A chaser that already sits at the quarry's coordinates does not look anything up and does not move.
- R5: A move happens only if the background colour returned for the destination pixel equals the floor colour register. The block raises `bg_rd` for one cycle with the destination on `bg_x`/`bg_y`, and it samples `bg_color` in the next cycle.
- R6: If the first axis is blocked and the chaser's distance along the other axis is nonzero, the block looks up and tries the other axis. If both axes are blocked, the chaser stays where it is.
- R7: The quarry sprite never moves under pursuit, even when its enable bit is set. Sprites whose enable bit is clear never move and cause no lookups.
- R8: After a chaser has been handled in a frame, its hit flag is set if its 8x8 box overlaps the quarry's box. Overlap means that both |dx| < 8 and |dy| < 8.
- R9: Hit flags stay set from frame to frame, even after the sprites separate. Writing 1 to a bit at address 3 clears that flag, and writing 0 bits leaves the flags unchanged.
- R10: Chasers are handled in ascending index order, and the background lookups follow that order. A frame tick that arrives while a frame is still being processed is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| frame_tick | input | 1 | Start-of-frame pulse |
| bg_rd | output | 1 | Background lookup strobe |
| bg_x | output | 10 | Lookup X coordinate |
| bg_y | output | 10 | Lookup Y coordinate |
| bg_color | input | 8 | Pixel colour, valid the cycle after `bg_rd` |
| hit_flags | output | 4 | Sticky per-sprite overlap flags |

## Verification
The assertions assume that `bg_color` answers the coordinate presented in the previous `bg_rd` cycle and then holds steady until the next strobe. They also assume that software does not rewrite positions, the quarry select or the enable mask while a frame is in progress. The stimulus keeps to both assumptions. The background model updates its colour only on a strobe, and every register write comes well after the block has finished the frame before it. The one exception is a second tick deliberately sent into a busy frame, which touches no register.

// File: rtl/chase_pkg.sv
package chase_pkg;
  localparam int COORD_W  = 10;
  localparam int COLOR_W  = 8;
  localparam int SPR_EDGE = 8;

  typedef logic [COORD_W-1:0] coord_t;
  typedef logic [COLOR_W-1:0] color_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_PROBE,
    ST_CHECK,
    ST_HIT
  } seq_state_t;

  function automatic coord_t gap(coord_t a, coord_t b);
    return (a >= b) ? coord_t'(a - b) : coord_t'(b - a);
  endfunction

  // one pixel from 'from' toward 'to'; only meaningful when they differ
  function automatic coord_t nudge(coord_t from, coord_t to);
    return (to > from) ? coord_t'(from + coord_t'(1)) : coord_t'(from - coord_t'(1));
  endfunction

  function automatic logic boxes_meet(coord_t ax, coord_t ay, coord_t bx, coord_t by);
    return (gap(ax, bx) < coord_t'(SPR_EDGE)) && (gap(ay, by) < coord_t'(SPR_EDGE));
  endfunction
endpackage

// File: rtl/chase_planner.sv
module chase_planner
  import chase_pkg::*;
(
  input  coord_t px,
  input  coord_t py,
  input  coord_t tx,
  input  coord_t ty,
  output coord_t first_x,
  output coord_t first_y,
  output logic   first_ok,
  output coord_t second_x,
  output coord_t second_y,
  output logic   second_ok
);
  coord_t dx, dy;
  logic   x_leads;

  always_comb begin
    dx      = gap(px, tx);
    dy      = gap(py, ty);
    x_leads = (dx >= dy);
    if (x_leads) begin
      first_x   = nudge(px, tx);
      first_y   = py;
      first_ok  = (dx != '0);
      second_x  = px;
      second_y  = nudge(py, ty);
      second_ok = (dy != '0);
    end else begin
      first_x   = px;
      first_y   = nudge(py, ty);
      first_ok  = 1'b1;
      second_x  = nudge(px, tx);
      second_y  = py;
      second_ok = (dx != '0);
    end
  end
endmodule

// File: rtl/chase_regs.sv
module chase_regs
  import chase_pkg::*;
#(
  parameter int N_SPR  = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int IDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [DATA_W-1:0]       rd_data,
  input  logic                    step_commit,
  input  logic [IDX_W-1:0]        step_idx,
  input  coord_t                  step_x,
  input  coord_t                  step_y,
  input  logic [N_SPR-1:0]        hit_set,
  output logic [N_SPR-1:0][COORD_W-1:0] pos_x,
  output logic [N_SPR-1:0][COORD_W-1:0] pos_y,
  output logic [IDX_W-1:0]        target_sel,
  output logic [N_SPR-1:0]        enable,
  output color_t                  bg_key,
  output logic [N_SPR-1:0]        hit_flags,
  output logic                    clr_write
);
  localparam int A_TGT  = 0;
  localparam int A_EN   = 1;
  localparam int A_KEY  = 2;
  localparam int A_HIT  = 3;
  localparam int A_BASE = 4;

  assign clr_write = wr_en && (wr_addr == ADDR_W'(A_HIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target_sel <= '0;
      enable     <= '0;
      bg_key     <= '0;
      hit_flags  <= '0;
    end else begin
      if (wr_en && wr_addr == ADDR_W'(A_TGT)) target_sel <= wr_data[IDX_W-1:0];
      if (wr_en && wr_addr == ADDR_W'(A_EN))  enable     <= wr_data[N_SPR-1:0];
      if (wr_en && wr_addr == ADDR_W'(A_KEY)) bg_key     <= wr_data[COLOR_W-1:0];
      // a new overlap wins over a clear in the same cycle
      hit_flags <= (hit_flags & ~(clr_write ? wr_data[N_SPR-1:0] : '0)) | hit_set;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_x <= '0;
      pos_y <= '0;
    end else begin
      for (int i = 0; i < N_SPR; i++) begin
        if (wr_en && wr_addr == ADDR_W'(A_BASE + 2*i))
          pos_x[i] <= wr_data[COORD_W-1:0];
        else if (step_commit && step_idx == IDX_W'(i))
          pos_x[i] <= step_x;
        if (wr_en && wr_addr == ADDR_W'(A_BASE + 2*i + 1))
          pos_y[i] <= wr_data[COORD_W-1:0];
        else if (step_commit && step_idx == IDX_W'(i))
          pos_y[i] <= step_y;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(A_TGT)) rd_data = DATA_W'(target_sel);
    if (rd_addr == ADDR_W'(A_EN))  rd_data = DATA_W'(enable);
    if (rd_addr == ADDR_W'(A_KEY)) rd_data = DATA_W'(bg_key);
    if (rd_addr == ADDR_W'(A_HIT)) rd_data = DATA_W'(hit_flags);
    for (int i = 0; i < N_SPR; i++) begin
      if (rd_addr == ADDR_W'(A_BASE + 2*i))     rd_data = DATA_W'(pos_x[i]);
      if (rd_addr == ADDR_W'(A_BASE + 2*i + 1)) rd_data = DATA_W'(pos_y[i]);
    end
  end
endmodule

// File: rtl/chase_seq.sv
module chase_seq
  import chase_pkg::*;
#(
  parameter int N_SPR = 4,
  parameter int IDX_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_tick,
  input  logic [N_SPR-1:0]        enable,
  input  logic [IDX_W-1:0]        target_sel,
  input  logic [N_SPR-1:0][COORD_W-1:0] pos_x,
  input  logic [N_SPR-1:0][COORD_W-1:0] pos_y,
  input  color_t                  bg_color,
  input  color_t                  bg_key,
  output logic                    bg_rd,
  output coord_t                  bg_x,
  output coord_t                  bg_y,
  output logic                    step_commit,
  output logic [IDX_W-1:0]        step_idx,
  output coord_t                  step_x,
  output coord_t                  step_y,
  output logic [N_SPR-1:0]        hit_set
);
  seq_state_t       state;
  logic [IDX_W-1:0] idx;
  coord_t           cand_x, cand_y, alt_x, alt_y;
  logic             alt_ok;

  coord_t p_fx, p_fy, p_sx, p_sy;
  logic   p_fok, p_sok;
  logic   live, last, floor_match;

  chase_planner u_plan (
    .px(coord_t'(pos_x[idx])), .py(coord_t'(pos_y[idx])),
    .tx(coord_t'(pos_x[target_sel])), .ty(coord_t'(pos_y[target_sel])),
    .first_x(p_fx), .first_y(p_fy), .first_ok(p_fok),
    .second_x(p_sx), .second_y(p_sy), .second_ok(p_sok)
  );

  assign live        = enable[idx] && (idx != target_sel);
  assign last        = (idx == IDX_W'(N_SPR-1));
  assign floor_match = (bg_color == bg_key);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      idx    <= '0;
      cand_x <= '0;
      cand_y <= '0;
      alt_x  <= '0;
      alt_y  <= '0;
      alt_ok <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (frame_tick) begin
          idx   <= '0;
          state <= ST_PICK;
        end
        ST_PICK: begin
          if (live) begin
            if (p_fok) begin
              cand_x <= p_fx;
              cand_y <= p_fy;
              alt_x  <= p_sx;
              alt_y  <= p_sy;
              alt_ok <= p_sok;
              state  <= ST_PROBE;
            end else begin
              state <= ST_HIT;
            end
          end else if (last) begin
            state <= ST_IDLE;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        ST_PROBE: state <= ST_CHECK;
        ST_CHECK: begin
          if (floor_match) begin
            state <= ST_HIT;
          end else if (alt_ok) begin
            cand_x <= alt_x;
            cand_y <= alt_y;
            alt_ok <= 1'b0;
            state  <= ST_PROBE;
          end else begin
            state <= ST_HIT;
          end
        end
        ST_HIT: begin
          if (last) begin
            state <= ST_IDLE;
          end else begin
            idx   <= idx + IDX_W'(1);
            state <= ST_PICK;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bg_rd       = (state == ST_PROBE);
  assign bg_x        = cand_x;
  assign bg_y        = cand_y;
  assign step_commit = (state == ST_CHECK) && floor_match;
  assign step_idx    = idx;
  assign step_x      = cand_x;
  assign step_y      = cand_y;

  always_comb begin
    hit_set = '0;
    if (state == ST_HIT &&
        boxes_meet(pos_x[idx], pos_y[idx], pos_x[target_sel], pos_y[target_sel]))
      hit_set[idx] = 1'b1;
  end
endmodule

// File: rtl/sprite_chase_ctrl.sv
module sprite_chase_ctrl
  import chase_pkg::*;
#(
  parameter  int N_SPR  = 4,
  parameter  int DATA_W = 16,
  localparam int ADDR_W = $clog2(4 + 2*N_SPR),
  localparam int IDX_W  = $clog2(N_SPR)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               frame_tick,
  output logic               bg_rd,
  output logic [COORD_W-1:0] bg_x,
  output logic [COORD_W-1:0] bg_y,
  input  logic [COLOR_W-1:0] bg_color,
  output logic [N_SPR-1:0]   hit_flags
);
  logic [N_SPR-1:0][COORD_W-1:0] pos_x, pos_y;
  logic [IDX_W-1:0] target_sel, step_idx;
  logic [N_SPR-1:0] enable, hit_set;
  color_t           bg_key;
  coord_t           step_x, step_y;
  logic             step_commit, clr_write;

  chase_regs #(.N_SPR(N_SPR), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .step_commit(step_commit), .step_idx(step_idx),
    .step_x(step_x), .step_y(step_y), .hit_set(hit_set),
    .pos_x(pos_x), .pos_y(pos_y), .target_sel(target_sel),
    .enable(enable), .bg_key(bg_key), .hit_flags(hit_flags),
    .clr_write(clr_write)
  );

  chase_seq #(.N_SPR(N_SPR), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .enable(enable), .target_sel(target_sel),
    .pos_x(pos_x), .pos_y(pos_y),
    .bg_color(bg_color), .bg_key(bg_key),
    .bg_rd(bg_rd), .bg_x(bg_x), .bg_y(bg_y),
    .step_commit(step_commit), .step_idx(step_idx),
    .step_x(step_x), .step_y(step_y), .hit_set(hit_set)
  );
endmodule

// File: rtl/sprite_chase_ctrl_chk.sv
module sprite_chase_ctrl_chk
  import chase_pkg::*;
#(
  parameter int N_SPR = 4,
  parameter int IDX_W = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    step_commit,
  input logic [IDX_W-1:0]        step_idx,
  input coord_t                  step_x,
  input coord_t                  step_y,
  input logic [N_SPR-1:0][COORD_W-1:0] pos_x,
  input logic [N_SPR-1:0][COORD_W-1:0] pos_y,
  input logic [IDX_W-1:0]        target_sel,
  input logic [N_SPR-1:0]        enable,
  input logic                    bg_rd,
  input color_t                  bg_color,
  input color_t                  bg_key,
  input logic [N_SPR-1:0]        hit_flags,
  input logic [N_SPR-1:0]        hit_set,
  input logic                    clr_write
);
  coord_t cur_x, cur_y;
  logic   x_unit, y_unit;
  assign cur_x  = pos_x[step_idx];
  assign cur_y  = pos_y[step_idx];
  assign x_unit = (step_x == coord_t'(cur_x + coord_t'(1))) || (coord_t'(step_x + coord_t'(1)) == cur_x);
  assign y_unit = (step_y == coord_t'(cur_y + coord_t'(1))) || (coord_t'(step_y + coord_t'(1)) == cur_y);

  AST_ONE_PIXEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_commit |-> ((x_unit && step_y == cur_y) || (y_unit && step_x == cur_x))); // R3

  AST_STEP_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    step_commit |-> ($past(bg_rd) && bg_color == bg_key)); // R5

  AST_QUARRY_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    step_commit |-> (step_idx != target_sel)); // R7

  AST_ENABLED_MOVER: assert property (@(posedge clk) disable iff (!rst_n)
    step_commit |-> enable[step_idx]); // R7

  AST_HIT_FROM_CHASER: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_set != '0) |-> (((hit_set & enable) == hit_set) && !hit_set[target_sel])); // R8

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_write |=> ((hit_flags & $past(hit_flags)) == $past(hit_flags))); // R9
endmodule

bind sprite_chase_ctrl sprite_chase_ctrl_chk #(.N_SPR(N_SPR), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .step_commit(step_commit), .step_idx(step_idx),
  .step_x(step_x), .step_y(step_y),
  .pos_x(pos_x), .pos_y(pos_y),
  .target_sel(target_sel), .enable(enable),
  .bg_rd(bg_rd), .bg_color(bg_color), .bg_key(bg_key),
  .hit_flags(hit_flags), .hit_set(hit_set), .clr_write(clr_write)
);

// File: tb/sprite_chase_ctrl_test.sv
module sprite_chase_ctrl_test;
  localparam int N = 4;
  localparam int FLOOR = 8'h11;
  localparam int WALL  = 8'hE0;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [3:0]  rd_addr = 0;
  logic [15:0] rd_data;
  logic        frame_tick = 0;
  logic        bg_rd;
  logic [9:0]  bg_x, bg_y;
  logic [7:0]  bg_color = 0;
  logic [3:0]  hit_flags;

  int total = 0;
  int bad = 0;
  int pending = 0;

  int    q_addr[$];
  int    q_val[$];
  string q_tag[$];
  int    look_exp[$];
  int    look_act[$];

  int mx[N], my[N];
  int mtgt, men, mkey, mflags;

  always #5 clk = ~clk;

  sprite_chase_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .frame_tick(frame_tick),
    .bg_rd(bg_rd), .bg_x(bg_x), .bg_y(bg_y), .bg_color(bg_color), .hit_flags(hit_flags)
  );

  function automatic int bg_of(int x, int y);
    if (x < 4 || y < 4 || x >= 300 || y >= 220) return WALL;
    if (x == 120 && y >= 90 && y <= 110) return WALL;
    return FLOOR;
  endfunction

  function automatic int iabs(int v);
    return v < 0 ? -v : v;
  endfunction

  // background memory: answers a strobe, holds otherwise
  always @(negedge clk) begin
    if (bg_rd) begin
      bg_color <= 8'(bg_of(int'(bg_x), int'(bg_y)));
      look_act.push_back(int'(bg_x) * 1024 + int'(bg_y));
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_reg(int a, int v, string tag);
    q_addr.push_back(a);
    q_val.push_back(v);
    q_tag.push_back(tag);
    pending++;
  endtask

  // monitor: pops expected items and compares against the read port
  initial begin
    forever begin
      int a, v;
      string t;
      wait (q_addr.size() != 0);
      a = q_addr.pop_front();
      v = q_val.pop_front();
      t = q_tag.pop_front();
      @(negedge clk);
      rd_addr = 4'(a);
      #1;
      chk(int'(rd_data) == v, t, int'(rd_data), v);
      pending--;
    end
  end

  task automatic drain();
    wait (pending == 0);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 0;
    case (a)
      0: mtgt = d & 3;
      1: men = d & 4'hF;
      2: mkey = d & 8'hFF;
      3: mflags = mflags & ~(d & 4'hF);
      default: if (((a - 4) % 2) == 0) mx[(a-4)/2] = d & 10'h3FF;
               else my[(a-4)/2] = d & 10'h3FF;
    endcase
  endtask

  task automatic place(int i, int x, int y);
    wr(4 + 2*i, x);
    wr(5 + 2*i, y);
  endtask

  function automatic bit try_move(int i, int nx, int ny);
    look_exp.push_back(nx * 1024 + ny);
    if (bg_of(nx, ny) == mkey) begin
      mx[i] = nx; my[i] = ny;
      return 1;
    end
    return 0;
  endfunction

  task automatic model_frame();
    for (int i = 0; i < N; i++) begin
      if (men[i] && i != mtgt) begin
        int dx, dy, sx, sy;
        bit moved;
        dx = iabs(mx[mtgt] - mx[i]);
        dy = iabs(my[mtgt] - my[i]);
        sx = mx[mtgt] > mx[i] ? 1 : -1;
        sy = my[mtgt] > my[i] ? 1 : -1;
        if (dx != 0 || dy != 0) begin
          if (dx >= dy) begin
            moved = try_move(i, mx[i] + sx, my[i]);
            if (!moved && dy != 0) moved = try_move(i, mx[i], my[i] + sy);
          end else begin
            moved = try_move(i, mx[i], my[i] + sy);
            if (!moved && dx != 0) moved = try_move(i, mx[i] + sx, my[i]);
          end
        end
        if (iabs(mx[i] - mx[mtgt]) < 8 && iabs(my[i] - my[mtgt]) < 8)
          mflags = mflags | (1 << i);
      end
    end
  endtask

  task automatic run_frame(string tag, bit double_tick);
    look_exp.delete();
    look_act.delete();
    @(negedge clk); frame_tick = 1;
    @(negedge clk); frame_tick = 0;
    if (double_tick) begin
      repeat (2) @(negedge clk);
      frame_tick = 1;
      @(negedge clk); frame_tick = 0;
    end
    repeat (40) @(negedge clk);
    model_frame();
    chk(look_act.size() == look_exp.size(), {tag, " lookup count R5 R10"},
        look_act.size(), look_exp.size());
    for (int k = 0; k < look_exp.size() && k < look_act.size(); k++)
      chk(look_act[k] == look_exp[k], {tag, " lookup order R10 R4 R6"}, look_act[k], look_exp[k]);
    for (int i = 0; i < N; i++) begin
      expect_reg(4 + 2*i, mx[i], {tag, " x R3 R4 R7"});
      expect_reg(5 + 2*i, my[i], {tag, " y R3 R4 R7"});
    end
    expect_reg(3, mflags, {tag, " hit reg R8 R9"});
    drain();
    chk(int'(hit_flags) == mflags, {tag, " hit port R8"}, int'(hit_flags), mflags);
  endtask

  initial begin
    #1_500_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mx[i] = 0; my[i] = 0; end
    mtgt = 0; men = 0; mkey = 0; mflags = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 12; a++) expect_reg(a, 0, "reset R1");
    drain();
    chk(hit_flags == 0, "reset port R1", int'(hit_flags), 0);

    // R2: map and field widths
    wr(0, 16'hFFFE); expect_reg(0, 2, "tgt width R2");
    wr(1, 16'hFFF5); expect_reg(1, 5, "enable width R2");
    wr(2, 16'hAB33); expect_reg(2, 8'h33, "key width R2");
    wr(10, 16'hFFFF); expect_reg(10, 10'h3FF, "x width R2");
    wr(11, 16'h0123); expect_reg(11, 10'h123, "y width R2");
    drain();

    // scenario A: open floor, quarry 0 enabled too (R7), sprite 3 disabled
    wr(2, FLOOR);
    wr(0, 0);
    place(0, 100, 100);
    place(1, 90, 95);
    place(2, 100, 80);
    place(3, 10, 10);
    wr(1, 4'b0111);
    for (int f = 0; f < 5; f++) run_frame("open", 0);

    // R10: second tick during a busy frame is ignored
    run_frame("busy tick R10", 1);

    // scenario B: wall blocks, detours along other axis (R6)
    wr(1, 0);
    place(0, 100, 100);
    place(1, 121, 100);
    place(2, 121, 105);
    place(3, 200, 100);
    wr(1, 4'b1110);
    for (int f = 0; f < 3; f++) run_frame("wall R6", 0);

    // R9: flag from scenario A persists; clear with 0 bits, then with a 1
    wr(3, 0);
    expect_reg(3, mflags, "clear zero R9");
    drain();
    wr(3, 4'b0010);
    expect_reg(3, mflags, "clear one R9");
    drain();
    chk(int'(hit_flags) == mflags, "clear port R9", int'(hit_flags), mflags);

    // R5: floor colour mismatch, nobody moves
    wr(2, 8'h22);
    run_frame("key mismatch R5", 0);

    // R4: tie goes to X; R8 overlap at distance 7 but not 8
    wr(2, FLOOR);
    wr(3, 4'hF);
    wr(1, 0);
    place(0, 150, 150);
    place(1, 140, 140);
    place(2, 158, 150);
    place(3, 150, 150);
    wr(1, 4'b1110);
    for (int f = 0; f < 3; f++) run_frame("tie/overlap R4 R8", 0);

    // R7: change quarry to 3, sprite 0 becomes a chaser
    wr(0, 3);
    wr(1, 4'b1001);
    place(0, 60, 60);
    run_frame("quarry swap R7", 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule